// File: doc/BRIEF.md
# Encoded-Ratio Clock Divider

This block takes a fast oscillator-rate clock and produces a slower clock whose division ratio comes from a 4-bit code. The code has two fields. The low two bits choose a base divisor from a small set that includes odd and prime values. The high two bits scale that base by 1, 2, 4 or 8. A build-time parameter selects one of two base sets. One suits a processor clock and uses bases {2, 3, 5, 15}. The other suits a serial-link reference and uses bases {2, 3, 5, 7}.

The divided clock is presented as a true output and a complement output. Every ratio, odd ones included, gives exactly 50% duty. For odd ratios the design adds a falling-edge stage that moves the rising transition forward by half an input cycle. An enable input parks both outputs low. Neither the code nor the enable acts at once: each is captured only at the end of the current output period, when the true output falls, so a reprogramming step never produces a runt pulse.

Reset is synchronous and active high. While reset is held, the block loads the code and enable that are present on its inputs. After reset is released, it starts a fresh period with its output low.

Top module: `ratio_clkdiv`

## Requirements
- R1: With the processor base set, the ratio N equals base × 2^code[3:2], where code[1:0] = 0, 1, 2, 3 selects base 2, 3, 5, 15. N therefore runs from 2 to 120 input cycles per output period.
- R2: With the serial-link base set, code[1:0] = 0, 1, 2, 3 selects base 2, 3, 5, 7, with the same scaling by code[3:2]. N therefore runs from 2 to 56.
- R3: While enabled, each high phase and each low phase of the true output lasts exactly N input half-periods, for odd N as well as even N.
- R4: While enabled, the complement output is the inverse of the true output at every half-period sample.
- R5: While the captured enable is 0, both the true output and the complement output are 0.
- R6: While reset is held, the true output is 0 and the complement output equals the enable input. After release, the first low phase lasts N half-periods, counted from the last clock edge that saw reset, using the code held during reset.
- R7: A new code takes effect only at the clock edge where the true output falls. The period in progress finishes with the old ratio. A code changed just after such an edge waits one whole period under the old ratio before it applies.
- R8: A new enable value also takes effect only at the edge where the true output falls. After enable is raised, the outputs stay parked until the next period boundary of the still-running counter, and then begin with a full low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate input clock. Both edges are used. |
| rst | input | 1 | Synchronous active-high reset. Loads code_in and en_in. |
| code_in | input | 4 | Ratio code: [1:0] selects the base divisor, [3:2] selects the power-of-two scale. |
| en_in | input | 1 | Output enable. A 0 parks both outputs low, applied at a period boundary. |
| clk_t | output | 1 | Divided clock, true polarity. |
| clk_c | output | 1 | Divided clock, complement polarity. |

## Verification
Two events can land on the same period boundary: the capture of a new ratio code and the capture of a raised enable. The bench sets up this coincidence by disabling the output, letting the counter run for two whole periods, and then changing the code and raising the enable in the same cycle. The run passes only if the outputs stay parked for exactly the remainder of one old-ratio period and then produce low and high phases at the new ratio, with no partial phase at the old one. A second case changes the code one sample after a boundary and expects exactly one further period at the old ratio.

// File: rtl/ratio_clkdiv_pkg.sv
`timescale 1ns/1ps
package ratio_clkdiv_pkg;

    // Width of the base-select field of the ratio code.
    localparam int unsigned SEL_W = 2;

    typedef enum logic {
        BASE_CPU = 1'b0,
        BASE_SRC = 1'b1
    } base_set_e;

    // Base divisor for one value of the select field.
    function automatic int unsigned base_of(base_set_e set, int unsigned sel);
        case (sel)
            0:       return 2;
            1:       return 3;
            2:       return 5;
            default: return (set == BASE_CPU) ? 15 : 7;
        endcase
    endfunction

    // Largest ratio the code space can reach, used to size the counter.
    function automatic int unsigned max_ratio(base_set_e set, int unsigned scl_w);
        int unsigned m;
        m = 0;
        for (int unsigned s = 0; s < (1 << SEL_W); s++) begin
            if (base_of(set, s) > m) m = base_of(set, s);
        end
        return m << ((1 << scl_w) - 1);
    endfunction

endpackage

// File: rtl/ratio_clkdiv_dec.sv
`timescale 1ns/1ps
module ratio_clkdiv_dec
    import ratio_clkdiv_pkg::*;
#(
    parameter base_set_e BASE_SET = BASE_CPU,
    parameter int        SCL_W    = 2,
    parameter int        RAT_W    = 7
) (
    input  logic [SEL_W+SCL_W-1:0] code,
    output logic [RAT_W-1:0]       ratio,
    output logic [RAT_W-1:0]       half_len,
    output logic                   odd
);

    logic [RAT_W-1:0] base;
    logic [RAT_W-1:0] top_base;

    // The parameter picks the largest base of the set.
    generate
        if (BASE_SET == BASE_CPU) begin : g_cpu_set
            assign top_base = RAT_W'(base_of(BASE_CPU, 3));
        end else begin : g_src_set
            assign top_base = RAT_W'(base_of(BASE_SRC, 3));
        end
    endgenerate

    always_comb begin
        case (code[SEL_W-1:0])
            2'd0:    base = RAT_W'(2);
            2'd1:    base = RAT_W'(3);
            2'd2:    base = RAT_W'(5);
            default: base = top_base;
        endcase
        ratio    = base << code[SEL_W +: SCL_W];
        // ceil(N/2): cycles of low phase counted on rising edges
        half_len = (ratio >> 1) + RAT_W'(ratio[0]);
        odd      = ratio[0];
    end

endmodule

// File: rtl/ratio_clkdiv_ctr.sv
`timescale 1ns/1ps
module ratio_clkdiv_ctr #(
    parameter int RAT_W  = 7,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              en_in,
    input  logic [RAT_W-1:0]  ratio,
    input  logic [RAT_W-1:0]  half_len,
    output logic [CODE_W-1:0] act_code,
    output logic              act_en,
    output logic [RAT_W-1:0]  cnt,
    output logic              hi
);

    typedef struct packed {
        logic [RAT_W-1:0]  cnt;
        logic              hi;
        logic [CODE_W-1:0] code;
        logic              en;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    wrap;
    logic [RAT_W-1:0] cnt_inc;

    always_comb begin
        wrap    = (st_q.cnt == ratio - 1'b1);
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        if (rst) begin
            st_d.cnt  = '0;
            st_d.hi   = 1'b0;
            st_d.code = code_in;
            st_d.en   = en_in;
        end else if (wrap) begin
            // period boundary: new settings are captured only here
            st_d.cnt  = '0;
            st_d.hi   = 1'b0;
            st_d.code = code_in;
            st_d.en   = en_in;
        end else begin
            st_d.cnt  = cnt_inc;
            st_d.hi   = (cnt_inc >= half_len);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign act_code = st_q.code;
    assign act_en   = st_q.en;
    assign cnt      = st_q.cnt;
    assign hi       = st_q.hi;

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < ratio);

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(st_q.code));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(st_q.en));

    // R3
    rise_point_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.hi) |-> (st_q.cnt == half_len));

    // R3
    high_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> st_q.hi);

endmodule

// File: rtl/ratio_clkdiv_lead.sv
`timescale 1ns/1ps
module ratio_clkdiv_lead #(
    parameter int RAT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RAT_W-1:0] cnt,
    input  logic [RAT_W-1:0] half_len,
    input  logic             odd,
    output logic             lead
);

    logic lead_d, lead_q;

    // For odd ratios the rise moves half a cycle earlier, into the
    // last low cycle, so both phases get N half-periods.
    always_comb begin
        lead_d = !rst && odd && (cnt == half_len - 1'b1);
    end

    always_ff @(negedge clk) begin
        lead_q <= lead_d;
    end

    assign lead = lead_q;

    // R3
    lead_odd_only_chk: assert property (@(negedge clk) disable iff (rst)
        lead_q |-> odd);

endmodule

// File: rtl/ratio_clkdiv.sv
`timescale 1ns/1ps
module ratio_clkdiv
    import ratio_clkdiv_pkg::*;
#(
    parameter base_set_e BASE_SET = BASE_CPU,
    parameter int        SCL_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W+SCL_W-1:0] code_in,
    input  logic                   en_in,
    output logic                   clk_t,
    output logic                   clk_c
);

    localparam int          CODE_W = SEL_W + SCL_W;
    localparam int unsigned MAX_R  = max_ratio(BASE_SET, SCL_W);
    localparam int          RAT_W  = $clog2(MAX_R + 1);

    logic [CODE_W-1:0] act_code;
    logic              act_en;
    logic [RAT_W-1:0]  ratio;
    logic [RAT_W-1:0]  half_len;
    logic              odd;
    logic [RAT_W-1:0]  cnt;
    logic              hi;
    logic              lead;
    logic              phase;

    ratio_clkdiv_dec #(
        .BASE_SET (BASE_SET),
        .SCL_W    (SCL_W),
        .RAT_W    (RAT_W)
    ) u_dec (
        .code     (act_code),
        .ratio    (ratio),
        .half_len (half_len),
        .odd      (odd)
    );

    ratio_clkdiv_ctr #(
        .RAT_W    (RAT_W),
        .CODE_W   (CODE_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .code_in  (code_in),
        .en_in    (en_in),
        .ratio    (ratio),
        .half_len (half_len),
        .act_code (act_code),
        .act_en   (act_en),
        .cnt      (cnt),
        .hi       (hi)
    );

    ratio_clkdiv_lead #(
        .RAT_W    (RAT_W)
    ) u_lead (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .half_len (half_len),
        .odd      (odd),
        .lead     (lead)
    );

    assign phase = hi | lead;
    assign clk_t = act_en & phase;
    assign clk_c = act_en & ~phase;

    // R8
    en_flip_low_chk: assert property (@(posedge clk) disable iff (rst)
        (act_en != $past(act_en)) |-> !hi);

    // R5
    parked_low_chk: assert property (@(posedge clk) disable iff (rst)
        !act_en |-> (!clk_t && !clk_c));

endmodule

// File: tb/sim_ratio_clkdiv.sv
`timescale 1ns/1ps
module sim_ratio_clkdiv;
    import ratio_clkdiv_pkg::*;

    logic       clk    = 1'b0;
    logic       rst    = 1'b1;
    logic [3:0] code_i = 4'b0000;
    logic       en_i   = 1'b1;
    logic       t0, c0, t1, c1;
    int         n_chk   = 0;
    int         n_bad   = 0;
    int         inv_bad = 0;

    always #2 clk = ~clk;

    ratio_clkdiv #(.BASE_SET(BASE_CPU)) u0 (
        .clk(clk), .rst(rst), .code_in(code_i), .en_in(en_i), .clk_t(t0), .clk_c(c0));
    ratio_clkdiv #(.BASE_SET(BASE_SRC)) u1 (
        .clk(clk), .rst(rst), .code_in(code_i), .en_in(en_i), .clk_t(t1), .clk_c(c1));

    function automatic int exp_n(int w, logic [3:0] code);
        int b;
        case (code[1:0])
            2'd0:    b = 2;
            2'd1:    b = 3;
            2'd2:    b = 5;
            default: b = (w == 0) ? 15 : 7;
        endcase
        return b << code[3:2];
    endfunction

    function automatic logic t_of(int w);
        return (w == 0) ? t0 : t1;
    endfunction

    function automatic logic c_of(int w);
        return (w == 0) ? c0 : c1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts consecutive half-period samples at level lvl, starting now.
    task automatic run_len(int w, logic lvl, output int len);
        len = 0;
        while (t_of(w) === lvl && len < 2000) begin
            if (c_of(w) !== ~lvl) inv_bad++;
            len++;
            #2;
        end
    endtask

    task automatic do_reset(logic [3:0] code, logic en);
        rst    = 1'b1;
        code_i = code;
        en_i   = en;
        repeat (2) @(posedge clk);
        #1;
        chk(t0 === 1'b0 && t1 === 1'b0, "R6 true output low in reset", int'(t0), 0);
        chk(c0 === en && c1 === en, "R6 complement follows enable in reset", int'(c0), int'(en));
        rst = 1'b0;
    endtask

    task automatic test_ratio(int w, logic [3:0] code);
        int n, l;
        n = exp_n(w, code);
        do_reset(code, 1'b1);
        inv_bad = 0;
        run_len(w, 1'b0, l);
        chk(l == n, "R6 first low phase after reset", l, n);
        run_len(w, 1'b1, l);
        chk(l == n, (w == 0) ? "R1 high phase length" : "R2 high phase length", l, n);
        run_len(w, 1'b0, l);
        chk(l == n, "R3 low phase length", l, n);
        chk(inv_bad == 0, "R4 complement inverse", inv_bad, 0);
    endtask

    task automatic test_code_change();
        int l;
        do_reset(4'b0001, 1'b1);
        run_len(0, 1'b0, l);
        chk(l == 3, "R6 low phase before change", l, 3);
        code_i = 4'b0010;
        #2;
        run_len(0, 1'b1, l);
        chk(l + 1 == 3, "R7 phase in progress keeps old ratio", l + 1, 3);
        run_len(0, 1'b0, l);
        chk(l == 5, "R7 new ratio low phase", l, 5);
        run_len(0, 1'b1, l);
        chk(l == 5, "R7 new ratio high phase", l, 5);
    endtask

    task automatic test_boundary_miss();
        int l;
        do_reset(4'b0010, 1'b1);
        run_len(0, 1'b0, l);
        run_len(0, 1'b1, l);
        chk(l == 5, "R3 odd high phase", l, 5);
        code_i = 4'b0001;
        run_len(0, 1'b0, l);
        chk(l == 5, "R7 late change waits a period (low)", l, 5);
        run_len(0, 1'b1, l);
        chk(l == 5, "R7 late change waits a period (high)", l, 5);
        run_len(0, 1'b0, l);
        chk(l == 3, "R7 late change then applies (low)", l, 3);
        run_len(0, 1'b1, l);
        chk(l == 3, "R7 late change then applies (high)", l, 3);
    endtask

    task automatic test_enable();
        int l, k, bad;
        do_reset(4'b0100, 1'b1);
        run_len(0, 1'b0, l);
        chk(l == 4, "R1 ratio 4 low phase", l, 4);
        en_i = 1'b0;
        #2;
        run_len(0, 1'b1, l);
        chk(l + 1 == 4, "R8 disable waits for period end", l + 1, 4);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (t0 !== 1'b0 || c0 !== 1'b0) bad++;
            #2;
        end
        chk(bad == 0, "R5 both outputs parked low", bad, 0);
        // enable and new code captured at the same boundary
        en_i   = 1'b1;
        code_i = 4'b0011;
        k = 0;
        while (c0 === 1'b0 && t0 === 1'b0 && k < 1000) begin
            k++;
            #2;
        end
        chk(k == 8, "R8 parked until next boundary", k, 8);
        inv_bad = 0;
        run_len(0, 1'b0, l);
        chk(l == 15, "R8 first low phase after enable at new ratio", l, 15);
        run_len(0, 1'b1, l);
        chk(l == 15, "R1 ratio 15 high phase", l, 15);
        chk(inv_bad == 0, "R4 complement after re-enable", inv_bad, 0);
    endtask

    initial begin
        for (int cd = 0; cd < 16; cd++) test_ratio(0, 4'(cd));
        for (int cd = 0; cd < 16; cd++) test_ratio(1, 4'(cd));
        test_code_change();
        test_boundary_miss();
        test_enable();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule